// File: doc/BRIEF.md
# JTAG Test Access Port with Instruction Decoder

This block is the test access port of a chip. It runs entirely on the test clock `tck`, so the system clock does not have to be running. It holds the sixteen-state TAP controller and a 4-bit instruction register. It also holds three private data registers: a single-stage bypass, a 32-bit identification word and a one-bit system reset stage. It decodes the instruction to pick which register sits between `tdi` and `tdo`.

The chip's boundary cells live outside the block. The block gives them a serial path out of `bnd_si` and back in on `bnd_so`. It also gives them the strobes that move the cells: a capture/shift enable, a shift select and an update pulse. A level `bnd_extest` tells the cells to drive their latched values onto the pins.

One instruction selects the reset stage. That stage drives `sys_rst_req` with no update latch, so the chip reset follows the stage as it shifts. The stage is not touched by the TAP controller's own reset state.

Top module: `jtag_tap`

## Requirements
- R1: `trst_n` low puts the controller in Test-Logic-Reset at once. Five rising `tck` edges with `tms` high reach Test-Logic-Reset from any state. In that state the instruction becomes IDCODE.
- R2: Under IDCODE the data scan returns the word {version[31:28], part[27:12], maker[11:1], 1'b1}, least significant bit first. With the default parameters this word is 0x0940303F, so the first data scan after reset returns it.
- R3: Capture-IR loads 4'b0001 into the instruction shift stage. An instruction scan therefore returns 1,0,0,0 in that order.
- R4: Instruction codes are EXTEST 0x0, IDCODE 0x1, SAMPLE_PRELOAD 0x2, RESET 0xC and BYPASS 0xF. They are shifted in least significant bit first and take effect on the rising edge that leaves Update-IR.
- R5: The bypass stage loads 0 in Capture-DR and is a single stage in Shift-DR. An N-bit scan returns 0 followed by the first N-1 input bits.
- R6: Any code not listed in R4, including the unimplemented high-impedance code, selects the bypass stage.
- R7: The reset stage has no capture action and only shifts. `sys_rst_req` equals the stage at all times, with no latch. A scan returns the stage's previous value.
- R8: A set reset stage stays set through Test-Logic-Reset and other instructions. The controller keeps operating while `sys_rst_req` is high. Only `trst_n` or shifting in a 0 clears the stage.
- R9: `bnd_extest` goes high on the edge that updates EXTEST into the instruction register. It stays low under SAMPLE_PRELOAD and every other instruction.
- R10: Under EXTEST or SAMPLE_PRELOAD:
  - `bnd_clk_en` is high in Capture-DR and Shift-DR.
  - `bnd_shift` is high in Shift-DR.
  - `bnd_update` is high in Update-DR.
  - `bnd_si` carries `tdi`, and `tdo` carries `bnd_so`.

  All three strobes stay low under every other instruction.
- R11: `tdo` and `tdo_en` change on the falling edge of `tck`. `tdo_en` is high only in Shift-IR and Shift-DR, and `tdo` is 0 whenever `tdo_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | Output enable for the tdo pad |
| bnd_si | output | 1 | Serial data into the external boundary chain |
| bnd_so | input | 1 | Serial data returning from the boundary chain |
| bnd_clk_en | output | 1 | Boundary chain clock enable (capture or shift) |
| bnd_shift | output | 1 | Boundary chain shift select |
| bnd_update | output | 1 | Boundary output latch update strobe |
| bnd_extest | output | 1 | Boundary cells drive the pins |
| sys_rst_req | output | 1 | Chip reset request from the reset stage |

## Verification
The embedded assertions check four things on every cycle:
- five high `tms` edges always land in Test-Logic-Reset;
- Capture-IR always leaves the 0001 pattern, and Capture-DR always clears the bypass stage;
- the reset request never moves outside a Shift-DR of the reset instruction;
- `tdo_en` appears only in shift states, and `bnd_extest` drops after Test-Logic-Reset.

Some properties need whole scans, so only the directed scenarios show them. These are the exact identification word, the bit order of the instruction codes and the one-bit delay of the bypass stage. The same holds for unknown codes falling back to bypass and the reset request surviving a TAP reset. The boundary strobes are checked against a small chain model in the bench.

// File: rtl/tap_pkg.sv
package tap_pkg;

   typedef enum logic [3:0] {
      ST_TLR, ST_RTI,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_e;

   typedef enum logic [1:0] {
      PATH_BYP, PATH_ID, PATH_RST, PATH_BND
   } dr_path_e;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
      case (s)
         ST_TLR:    return m ? ST_TLR    : ST_RTI;
         ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
         ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
         ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
         default:   return m ? ST_SEL_DR : ST_RTI;
      endcase
   endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_TLR;
      else         state <= tap_next(state, tms);
   end

   // checker: consecutive high tms edges, saturating at five
   logic [2:0] hi_run;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)           hi_run <= 3'd0;
      else if (!tms)         hi_run <= 3'd0;
      else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
   end

   // R1
   five_high_tlr_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (hi_run == 3'd5) |-> (state == ST_TLR));

endmodule

// File: rtl/tap_ir_dec.sv
module tap_ir_dec
   import tap_pkg::*;
#(
   parameter int unsigned IR_W = 4,
   parameter logic [IR_W-1:0] OP_EXTEST = 'h0,
   parameter logic [IR_W-1:0] OP_IDCODE = 'h1,
   parameter logic [IR_W-1:0] OP_SAMPLE = 'h2,
   parameter logic [IR_W-1:0] OP_RESET  = 'hC,
   parameter logic [IR_W-1:0] OP_BYPASS = '1
)(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tdi,
   input  tap_state_e state,
   output logic       ir_lsb,
   output dr_path_e   path,
   output logic       extest
);

   localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-1){1'b0}}, 1'b1};

   if (IR_W < 2) begin : g_bad_irw
      $error("tap_ir_dec: IR_W must be at least 2");
   end
   if (OP_BYPASS != {IR_W{1'b1}}) begin : g_bad_byp
      $error("tap_ir_dec: bypass code must be all ones");
   end
   if (OP_IDCODE == OP_EXTEST || OP_SAMPLE == OP_EXTEST || OP_RESET == OP_IDCODE) begin : g_bad_ops
      $error("tap_ir_dec: instruction codes collide");
   end

   logic [IR_W-1:0] ir_sr, ir_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sr <= CAP_PAT;
         ir_q  <= OP_IDCODE;
      end else begin
         case (state)
            ST_CAP_IR: ir_sr <= CAP_PAT;
            ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            default:   ir_sr <= ir_sr;
         endcase
         if (state == ST_TLR)      ir_q <= OP_IDCODE;
         else if (state == ST_UPD_IR) ir_q <= ir_sr;
      end
   end

   always_comb begin
      if (ir_q == OP_IDCODE)                          path = PATH_ID;
      else if (ir_q == OP_RESET)                      path = PATH_RST;
      else if (ir_q == OP_EXTEST || ir_q == OP_SAMPLE) path = PATH_BND;
      else                                            path = PATH_BYP;
   end

   assign extest = (ir_q == OP_EXTEST);
   assign ir_lsb = ir_sr[0];

   // R3
   cap_ir_pat_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_CAP_IR) |=> (ir_sr == CAP_PAT));

endmodule

// File: rtl/tap_dr_bank.sv
module tap_dr_bank
   import tap_pkg::*;
#(
   parameter int unsigned ID_W = 32,
   parameter logic [3:0]  ID_VERSION = 4'h0,
   parameter logic [15:0] ID_PART    = 16'h9403,
   parameter logic [10:0] ID_MAKER   = 11'h01F
)(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tdi,
   input  tap_state_e state,
   input  dr_path_e   path,
   input  logic       bnd_so,
   output logic       dr_lsb,
   output logic       rst_req
);

   localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

   if (ID_W != 32) begin : g_bad_idw
      $error("tap_dr_bank: identification word must be 32 bits");
   end

   logic [ID_W-1:0] id_sr;
   logic            byp_q, rst_q;
   logic            cap, sh;

   assign cap = (state == ST_CAP_DR);
   assign sh  = (state == ST_SH_DR);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         id_sr <= ID_WORD;
         byp_q <= 1'b0;
         rst_q <= 1'b0;
      end else begin
         if (path == PATH_ID) begin
            if (cap)     id_sr <= ID_WORD;
            else if (sh) id_sr <= {tdi, id_sr[ID_W-1:1]};
         end
         if (path == PATH_BYP) begin
            if (cap)     byp_q <= 1'b0;
            else if (sh) byp_q <= tdi;
         end
         if (path == PATH_RST && sh) rst_q <= tdi;
      end
   end

   always_comb begin
      case (path)
         PATH_ID:  dr_lsb = id_sr[0];
         PATH_RST: dr_lsb = rst_q;
         PATH_BND: dr_lsb = bnd_so;
         default:  dr_lsb = byp_q;
      endcase
   end

   assign rst_req = rst_q;

   // R5
   byp_cap_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (cap && path == PATH_BYP) |=> (byp_q == 1'b0));

   // R8
   rst_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      !(sh && path == PATH_RST) |=> $stable(rst_req));

endmodule

// File: rtl/jtag_tap.sv
module jtag_tap
   import tap_pkg::*;
#(
   parameter int unsigned IR_W = 4,
   parameter logic [3:0]  ID_VERSION = 4'h0,
   parameter logic [15:0] ID_PART    = 16'h9403,
   parameter logic [10:0] ID_MAKER   = 11'h01F
)(
   input  logic tck,
   input  logic trst_n,
   input  logic tms,
   input  logic tdi,
   output logic tdo,
   output logic tdo_en,
   output logic bnd_si,
   input  logic bnd_so,
   output logic bnd_clk_en,
   output logic bnd_shift,
   output logic bnd_update,
   output logic bnd_extest,
   output logic sys_rst_req
);

   tap_state_e state;
   dr_path_e   path;
   logic       ir_lsb, dr_lsb, bnd_sel;

   tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (state)
   );

   tap_ir_dec #(.IR_W(IR_W)) u_ir (
      .tck    (tck),
      .trst_n (trst_n),
      .tdi    (tdi),
      .state  (state),
      .ir_lsb (ir_lsb),
      .path   (path),
      .extest (bnd_extest)
   );

   tap_dr_bank #(
      .ID_VERSION (ID_VERSION),
      .ID_PART    (ID_PART),
      .ID_MAKER   (ID_MAKER)
   ) u_dr (
      .tck     (tck),
      .trst_n  (trst_n),
      .tdi     (tdi),
      .state   (state),
      .path    (path),
      .bnd_so  (bnd_so),
      .dr_lsb  (dr_lsb),
      .rst_req (sys_rst_req)
   );

   assign bnd_sel    = (path == PATH_BND);
   assign bnd_si     = tdi;
   assign bnd_shift  = bnd_sel && (state == ST_SH_DR);
   assign bnd_clk_en = bnd_sel && (state == ST_SH_DR || state == ST_CAP_DR);
   assign bnd_update = bnd_sel && (state == ST_UPD_DR);

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
         tdo    <= (state == ST_SH_IR) ? ir_lsb :
                   (state == ST_SH_DR) ? dr_lsb : 1'b0;
      end
   end

   // R11
   tdo_en_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

   // R9
   extest_drop_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_TLR) |=> !bnd_extest);

endmodule

// File: tb/tb_jtag_tap.sv
module tb_jtag_tap;

   localparam time CLK_P = 20ns;
   localparam logic [31:0] ID_EXP = 32'h0940303F;

   logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, bnd_so;
   logic tdo, tdo_en, bnd_si, bnd_clk_en, bnd_shift, bnd_update, bnd_extest, sys_rst_req;
   int checks = 0, failures = 0;
   bit done = 0;
   logic en_seen;

   always #(CLK_P/2) tck = ~tck;

   jtag_tap dut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
      .bnd_si(bnd_si), .bnd_so(bnd_so), .bnd_clk_en(bnd_clk_en), .bnd_shift(bnd_shift),
      .bnd_update(bnd_update), .bnd_extest(bnd_extest), .sys_rst_req(sys_rst_req)
   );

   // model of an 8-cell boundary chain
   logic [7:0] chain, latch;
   int strobes;
   always @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         chain <= 8'h00; latch <= 8'h00; strobes <= 0;
      end else begin
         if (bnd_clk_en) chain <= bnd_shift ? {bnd_si, chain[7:1]} : 8'hA5;
         if (bnd_update) latch <= chain;
         if (bnd_clk_en || bnd_shift || bnd_update) strobes <= strobes + 1;
      end
   end
   assign bnd_so = chain[0];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d, output logic q);
      @(negedge tck); #1;
      q = tdo;
      if (tdo_en) en_seen = 1'b1;
      tms = m; tdi = d;
   endtask

   task automatic idle();
      logic q;
      step(1'b0, 1'b0, q);
   endtask

   task automatic scan_ir(input logic [3:0] op, output logic [3:0] cap);
      logic q;
      step(1, 0, q); step(1, 0, q); step(0, 0, q); step(0, 0, q);
      for (int i = 0; i < 4; i++) begin
         step(i == 3, op[i], q);
         cap[i] = q;
      end
      step(1, 0, q); step(0, 0, q); idle();
   endtask

   task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
      logic q;
      dout = '0;
      step(1, 0, q); step(0, 0, q); step(0, 0, q);
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i], q);
         dout[i] = q;
      end
      step(1, 0, q); step(0, 0, q); idle();
   endtask

   task automatic goto_tlr();
      logic q;
      for (int i = 0; i < 5; i++) step(1, 0, q);
      step(0, 0, q); idle();
   endtask

   task automatic t_reset();
      trst_n = 1'b0; tms = 1'b1;
      #(CLK_P * 2);
      chk("R11 tdo_en in reset", tdo_en, 0);
      chk("R7 sys_rst_req in reset", sys_rst_req, 0);
      chk("R9 extest in reset", bnd_extest, 0);
      @(negedge tck); trst_n = 1'b1;
      idle(); idle();
   endtask

   task automatic t_idcode_first();
      logic [31:0] o;
      int s0;
      s0 = strobes;
      scan_dr(32, 32'h0, o);
      chk("R2 first scan id word", o, ID_EXP);
      chk("R10 no strobes under IDCODE", strobes - s0, 0);
   endtask

   task automatic t_ir_capture();
      logic [3:0] c;
      en_seen = 1'b0;
      scan_ir(4'hF, c);
      chk("R3 capture-ir pattern", {28'h0, c}, 32'h1);
      chk("R11 tdo_en seen in shift", en_seen, 1);
      chk("R11 tdo_en low in idle", tdo_en, 0);
      chk("R11 tdo zero in idle", tdo, 0);
   endtask

   task automatic t_bypass();
      logic [31:0] o;
      scan_dr(8, 32'hB6, o);
      chk("R5 R4 bypass delay", o, 32'h6C);
   endtask

   task automatic t_unknown();
      logic [3:0] c;
      logic [31:0] o;
      scan_ir(4'h5, c);
      scan_dr(8, 32'h5A, o);
      chk("R6 unknown code is bypass", o, 32'hB4);
      scan_ir(4'h8, c);
      scan_dr(8, 32'h81, o);
      chk("R6 high-z code is bypass", o, 32'h02);
   endtask

   task automatic t_reset_reg();
      logic [3:0] c;
      logic [31:0] o;
      scan_ir(4'hC, c);
      scan_dr(1, 32'h1, o);
      chk("R7 reset scan returns old", o, 0);
      chk("R7 reset request set", sys_rst_req, 1);
      scan_ir(4'hF, c);
      chk("R8 tap works under reset", {28'h0, c}, 32'h1);
      chk("R8 reset survives other instr", sys_rst_req, 1);
      goto_tlr();
      chk("R8 reset survives tlr", sys_rst_req, 1);
      scan_dr(32, 32'h0, o);
      chk("R1 tlr restores idcode", o, ID_EXP);
      scan_ir(4'hC, c);
      scan_dr(2, 32'h1, o);
      chk("R7 reset two-bit scan out", o, 32'h3);
      chk("R7 reset cleared by shift", sys_rst_req, 0);
   endtask

   task automatic t_boundary();
      logic [3:0] c;
      logic [31:0] o;
      logic q;
      scan_ir(4'h2, c);
      chk("R9 sample keeps extest low", bnd_extest, 0);
      scan_dr(8, 32'h3C, o);
      chk("R10 chain capture out", o, 32'hA5);
      chk("R10 chain update latch", {24'h0, latch}, 32'h3C);
      scan_ir(4'h0, c);
      chk("R9 extest high after update", bnd_extest, 1);
      step(1, 0, q); step(0, 0, q); step(0, 0, q); step(0, 0, q);
      goto_tlr();
      chk("R1 tlr from shift-dr drops extest", bnd_extest, 0);
      scan_dr(32, 32'h0, o);
      chk("R1 id after tlr", o, ID_EXP);
   endtask

   initial begin
      #(CLK_P * 50000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_idcode_first();
      t_ir_capture();
      t_bypass();
      t_unknown();
      t_reset_reg();
      t_boundary();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule